// File: doc/BRIEF.md
# Video Active Line Window Generator

This block numbers the lines of an interlaced video frame and marks the lines that belong to the coded picture. It counts line-start pulses, restarts at a frame-start pulse, and reports the current line number together with a field-parity flag. It also gives an active-line qualifier that tells downstream capture logic which lines to store, and single-cycle pulses on the first and last line of each field's picture window.

Two line standards are supported: a 525-line frame and a 625-line frame. Each has a normal picture height and a taller mode that takes more lines from the edges of each field. A host-written start-line register can move both field windows without changing their height. The selected standard, the tall mode and the register are all sampled only at a frame start. A frame that is already running therefore keeps one fixed window for its whole length.

Top module: `vid_line_window`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `line_num_o` is 1, `field_o` is 0, and `active_o`, `first_o` and `last_o` are 0.
- R2: The cycle after `frame_start_i`, `line_num_o` is 1. This also holds when `line_start_i` is high in the same cycle. The cycle after a lone `line_start_i`, the number goes up by one. After the last line (525 when `std625_i`=0, 625 when `std625_i`=1) the next number is 1.
- R3: `field_o` is 0 on lines 1..262 of a 525-line frame and on lines 1..312 of a 625-line frame. It is 1 on every higher line.
- R4: In 525-line normal mode (`tall_i`=0), the active lines are 22..261 and 285..524. In 525-line frames, lines 14 and 21 are never active, in either mode.
- R5: In 525-line tall mode (`tall_i`=1), the windows are 22−12..261+4 = 10..265 and 273..528. Numbers above 525 wrap, so lines 1..3 are active.
- R6: In 625-line normal mode, the active lines are 23..310 and 336..623.
- R7: In 625-line tall mode, the active lines are 9..312 and 322..625.
- R8: A register value V from 1 up to the frame length makes V the first active line of the first field. All four window bounds move by V minus the default first-field start, modulo the frame length, so each window keeps its height. A value of 0, or a value above the frame length, selects the default windows.
- R9: `std625_i`, `tall_i` and the register value are taken only at `frame_start_i`. A register write in the same cycle as a frame start takes effect at the frame start after that.
- R10: `first_o` and `last_o` each pulse for one cycle, in the cycle where `line_num_o` first shows a window's start or end line. The reserved-line rule of R4 does not suppress them, and neither pulses in a cycle that follows a cycle with no line or frame pulse.
- R11: In the cycle after a cycle with no line or frame pulse, `line_num_o`, `field_o` and `active_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| frame_start_i | input | 1 | One-cycle pulse at the start of each frame |
| std625_i | input | 1 | Standard select: 0 = 525 lines, 1 = 625 lines |
| tall_i | input | 1 | 1 selects the extended picture height |
| first_wr_i | input | 1 | Write strobe for the start-line register |
| first_data_i | input | 10 | Start-line value written on `first_wr_i` |
| line_num_o | output | 10 | Current line number, 1-based |
| field_o | output | 1 | Field parity of the current line |
| active_o | output | 1 | Current line belongs to the coded picture |
| first_o | output | 1 | Pulse on the first line of a field window |
| last_o | output | 1 | Pulse on the last line of a field window |

## Verification
A wrong line count shows at the ports in the cycle after the faulty line pulse. A wrong active flag or a misplaced marker shows on the very line where a window bound is wrong. An error in the sampled mode is hidden until a line that depends on it comes up. That can be as late as the wrap-around lines at the end of the frame. For this reason every mode is run through more than a full frame, and the outputs are compared with the reference model on every clock.

// File: rtl/vlw_pkg.sv
package vlw_pkg;

  localparam int unsigned LINE_W = 10;
  localparam int unsigned CALC_W = LINE_W + 1;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [CALC_W-1:0] calc_t;

  typedef struct packed {
    logic  std625;
    logic  tall;
    line_t first;
  } mode_t;

  typedef struct packed {
    line_t start;
    line_t stop;
  } span_t;

  localparam line_t TOTAL_A = line_t'(525);
  localparam line_t TOTAL_B = line_t'(625);
  localparam line_t HALF_A  = line_t'(262);
  localparam line_t HALF_B  = line_t'(312);
  localparam line_t TC_LINE = line_t'(14);
  localparam line_t CC_LINE = line_t'(21);

  function automatic line_t def_start(input logic std625, input logic tall, input logic fld);
    case ({std625, tall, fld})
      3'b000:  return line_t'(22);
      3'b001:  return line_t'(285);
      3'b010:  return line_t'(10);
      3'b011:  return line_t'(273);
      3'b100:  return line_t'(23);
      3'b101:  return line_t'(336);
      3'b110:  return line_t'(9);
      default: return line_t'(322);
    endcase
  endfunction

  function automatic line_t def_len(input logic std625, input logic tall);
    case ({std625, tall})
      2'b00:   return line_t'(240);
      2'b01:   return line_t'(256);
      2'b10:   return line_t'(288);
      default: return line_t'(304);
    endcase
  endfunction

  function automatic line_t wrap_line(input calc_t x, input line_t total);
    return (x > calc_t'(total)) ? line_t'(x - calc_t'(total)) : line_t'(x);
  endfunction

endpackage

// File: rtl/vlw_mode_latch.sv
module vlw_mode_latch
  import vlw_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  frame_start_i,
  input  logic  std625_i,
  input  logic  tall_i,
  input  logic  wr_i,
  input  line_t wdata_i,
  output mode_t mode_next_o,
  output mode_t mode_cur_o
);

  line_t host_q;
  mode_t mode_q;
  mode_t mode_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_q <= '0;
    end else if (wr_i) begin
      host_q <= wdata_i;
    end
  end

  always_comb begin
    mode_live.std625 = std625_i;
    mode_live.tall   = tall_i;
    mode_live.first  = host_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (frame_start_i) begin
      mode_q <= mode_live;
    end
  end

  assign mode_next_o = frame_start_i ? mode_live : mode_q;
  assign mode_cur_o  = mode_q;

endmodule

// File: rtl/vlw_window_calc.sv
module vlw_window_calc
  import vlw_pkg::*;
(
  input  mode_t       mode_i,
  output span_t [1:0] win_o,
  output line_t       total_o,
  output line_t       half_o
);

  line_t total;
  line_t len;
  line_t base0;
  line_t delta;
  logic  use_host;

  always_comb begin
    total    = mode_i.std625 ? TOTAL_B : TOTAL_A;
    half_o   = mode_i.std625 ? HALF_B : HALF_A;
    len      = def_len(mode_i.std625, mode_i.tall);
    base0    = def_start(mode_i.std625, mode_i.tall, 1'b0);
    use_host = (mode_i.first != '0) && (mode_i.first <= total);
    if (!use_host) begin
      delta = '0;
    end else if (mode_i.first >= base0) begin
      delta = mode_i.first - base0;
    end else begin
      delta = line_t'(calc_t'(mode_i.first) + calc_t'(total) - calc_t'(base0));
    end
  end

  assign total_o = total;

  for (genvar f = 0; f < 2; f++) begin : g_field
    calc_t raw_start;
    calc_t raw_stop;
    line_t start;
    span_t w;
    always_comb begin
      raw_start = calc_t'(def_start(mode_i.std625, mode_i.tall, (f == 1))) + calc_t'(delta);
      start     = wrap_line(raw_start, total);
      raw_stop  = calc_t'(start) + calc_t'(len) - calc_t'(1);
      w.start   = start;
      w.stop    = wrap_line(raw_stop, total);
    end
    assign win_o[f] = w;
  end

endmodule

// File: rtl/vlw_line_track.sv
module vlw_line_track
  import vlw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_start_i,
  input  logic        line_start_i,
  input  logic        std625_i,
  input  span_t [1:0] win_i,
  input  line_t       total_i,
  input  line_t       half_i,
  output line_t       line_o,
  output logic        field_o,
  output logic        active_o,
  output logic        first_o,
  output logic        last_o
);

  line_t      line_q;
  logic       field_q;
  logic       active_q;
  logic       first_q;
  logic       last_q;
  logic       ev;
  line_t      nxt;
  logic       reserved;
  logic [1:0] in_win;
  logic [1:0] hit_start;
  logic [1:0] hit_stop;

  always_comb begin
    ev = frame_start_i | line_start_i;
    if (frame_start_i) begin
      nxt = line_t'(1);
    end else if (line_q >= total_i) begin
      nxt = line_t'(1);
    end else begin
      nxt = line_q + line_t'(1);
    end
    reserved = !std625_i && ((nxt == TC_LINE) || (nxt == CC_LINE));
  end

  for (genvar f = 0; f < 2; f++) begin : g_win
    always_comb begin
      if (win_i[f].start <= win_i[f].stop) begin
        in_win[f] = (nxt >= win_i[f].start) && (nxt <= win_i[f].stop);
      end else begin
        in_win[f] = (nxt >= win_i[f].start) || (nxt <= win_i[f].stop);
      end
      hit_start[f] = (nxt == win_i[f].start);
      hit_stop[f]  = (nxt == win_i[f].stop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= line_t'(1);
      field_q  <= 1'b0;
      active_q <= 1'b0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      first_q <= ev & (|hit_start);
      last_q  <= ev & (|hit_stop);
      if (ev) begin
        line_q   <= nxt;
        field_q  <= (nxt > half_i);
        active_q <= (|in_win) & ~reserved;
      end
    end
  end

  assign line_o   = line_q;
  assign field_o  = field_q;
  assign active_o = active_q;
  assign first_o  = first_q;
  assign last_o   = last_q;

endmodule

// File: rtl/vid_line_window.sv
module vid_line_window
  import vlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start_i,
  input  logic              frame_start_i,
  input  logic              std625_i,
  input  logic              tall_i,
  input  logic              first_wr_i,
  input  logic [LINE_W-1:0] first_data_i,
  output logic [LINE_W-1:0] line_num_o,
  output logic              field_o,
  output logic              active_o,
  output logic              first_o,
  output logic              last_o
);

  mode_t       mode_next;
  mode_t       mode_cur;
  span_t [1:0] win;
  line_t       total;
  line_t       half;

  vlw_mode_latch u_mode (
    .clk          (clk),
    .rst          (rst),
    .frame_start_i(frame_start_i),
    .std625_i     (std625_i),
    .tall_i       (tall_i),
    .wr_i         (first_wr_i),
    .wdata_i      (first_data_i),
    .mode_next_o  (mode_next),
    .mode_cur_o   (mode_cur)
  );

  vlw_window_calc u_win (
    .mode_i (mode_next),
    .win_o  (win),
    .total_o(total),
    .half_o (half)
  );

  vlw_line_track u_track (
    .clk          (clk),
    .rst          (rst),
    .frame_start_i(frame_start_i),
    .line_start_i (line_start_i),
    .std625_i     (mode_next.std625),
    .win_i        (win),
    .total_i      (total),
    .half_i       (half),
    .line_o       (line_num_o),
    .field_o      (field_o),
    .active_o     (active_o),
    .first_o      (first_o),
    .last_o       (last_o)
  );

endmodule

// File: rtl/vlw_checker.sv
module vlw_checker
  import vlw_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  line_start_i,
  input logic  frame_start_i,
  input line_t line_num_o,
  input logic  field_o,
  input logic  active_o,
  input logic  first_o,
  input logic  last_o,
  input mode_t cur_mode
);

  line_t tot;
  line_t hlf;
  assign tot = cur_mode.std625 ? TOTAL_B : TOTAL_A;
  assign hlf = cur_mode.std625 ? HALF_B : HALF_A;

  a_r2_frame_restart: assert property (@(posedge clk) disable iff (rst)
    frame_start_i |=> (line_num_o == line_t'(1)));

  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (line_start_i && !frame_start_i && line_num_o != tot) |=> (line_num_o == $past(line_num_o) + line_t'(1)));

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (line_start_i && !frame_start_i && line_num_o == tot) |=> (line_num_o == line_t'(1)));

  a_r3_field_side: assert property (@(posedge clk) disable iff (rst)
    field_o == (line_num_o > hlf));

  a_r4_reserved_lines: assert property (@(posedge clk) disable iff (rst)
    (!cur_mode.std625 && (line_num_o == TC_LINE || line_num_o == CC_LINE)) |-> !active_o);

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_start_i) |-> $stable(cur_mode));

  a_r10_quiet_markers: assert property (@(posedge clk) disable iff (rst)
    !$past(line_start_i || frame_start_i) |-> (!first_o && !last_o));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(line_start_i || frame_start_i) |-> ($stable(line_num_o) && $stable(field_o) && $stable(active_o)));

endmodule

bind vid_line_window vlw_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .line_start_i (line_start_i),
  .frame_start_i(frame_start_i),
  .line_num_o   (line_num_o),
  .field_o      (field_o),
  .active_o     (active_o),
  .first_o      (first_o),
  .last_o       (last_o),
  .cur_mode     (mode_cur)
);

// File: tb/vid_line_window_tb.sv
module vid_line_window_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ls = 1'b0;
  logic       fs = 1'b0;
  logic       std_r = 1'b0;
  logic       tall_r = 1'b0;
  logic       wr = 1'b0;
  logic [9:0] wd = '0;
  logic [9:0] line_num;
  logic       field, active, first_p, last_p;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int  m_line = 1, m_field = 0, m_active = 0, m_first = 0, m_last = 0;
  int  cur_std = 0, cur_tall = 0, cur_first = 0, m_host = 0;
  bit  last_ev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_line_window u_dut (
    .clk          (clk),
    .rst          (rst),
    .line_start_i (ls),
    .frame_start_i(fs),
    .std625_i     (std_r),
    .tall_i       (tall_r),
    .first_wr_i   (wr),
    .first_data_i (wd),
    .line_num_o   (line_num),
    .field_o      (field),
    .active_o     (active),
    .first_o      (first_p),
    .last_o       (last_p)
  );

  function automatic int dstart(int s, int t, int f);
    if (s == 0) return (t == 0) ? ((f == 0) ? 22 : 285) : ((f == 0) ? 10 : 273);
    return (t == 0) ? ((f == 0) ? 23 : 336) : ((f == 0) ? 9 : 322);
  endfunction

  function automatic int dlen(int s, int t);
    if (s == 0) return (t == 0) ? 240 : 256;
    return (t == 0) ? 288 : 304;
  endfunction

  task automatic model_step(bit f_s, bit l_s, bit w, int d);
    int total, len, s, e;
    bit ev;
    ev = f_s || l_s;
    if (f_s) begin
      cur_std = std_r; cur_tall = tall_r; cur_first = m_host;
    end
    if (w) m_host = d;
    total = cur_std ? 625 : 525;
    len = dlen(cur_std, cur_tall);
    m_first = 0; m_last = 0;
    if (ev) begin
      m_line = f_s ? 1 : (m_line % total) + 1;
      m_field = (m_line > (cur_std ? 312 : 262)) ? 1 : 0;
      m_active = 0;
      for (int f = 0; f < 2; f++) begin
        s = dstart(cur_std, cur_tall, f);
        if (cur_first >= 1 && cur_first <= total)
          s = ((s - 1 + cur_first - dstart(cur_std, cur_tall, 0) + total) % total) + 1;
        e = ((s - 1 + len - 1) % total) + 1;
        if (((m_line - s + total) % total) < len) m_active = 1;
        if (m_line == s) m_first = 1;
        if (m_line == e) m_last = 1;
      end
      if (cur_std == 0 && (m_line == 14 || m_line == 21)) m_active = 0;
    end
    last_ev = ev;
  endtask

  task automatic compare();
    bit bad = 0;
    string hold_tag;
    hold_tag = last_ev ? "" : " R11";
    compared++;
    if (int'(line_num) != m_line) begin
      $display("FAIL R2%s line: got %0d exp %0d", hold_tag, line_num, m_line); bad = 1;
    end
    if (int'(field) != m_field) begin
      $display("FAIL R3%s field at line %0d: got %0d exp %0d", hold_tag, m_line, field, m_field); bad = 1;
    end
    if (int'(active) != m_active) begin
      $display("FAIL %s%s active at line %0d: got %0d exp %0d", cur_req, hold_tag, m_line, active, m_active); bad = 1;
    end
    if (int'(first_p) != m_first || int'(last_p) != m_last) begin
      $display("FAIL R10 markers at line %0d: got %0d/%0d exp %0d/%0d", m_line, first_p, last_p, m_first, m_last); bad = 1;
    end
    if (bad) mismatched++;
  endtask

  task automatic tick(bit f_s, bit l_s, bit w, int d);
    fs = f_s; ls = l_s; wr = w; wd = 10'(d);
    model_step(f_s, l_s, w, d);
    @(negedge clk);
    compare();
  endtask

  task automatic run_lines(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick(0, 1, 0, 0);
      for (int g = 0; g < gap; g++) tick(0, 0, 0, 0);
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state, held for several cycles
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compare();
    end
    rst = 1'b0;
    tick(0, 0, 0, 0);

    cur_req = "R4";  std_r = 0; tall_r = 0;
    tick(1, 0, 0, 0); run_lines(530, 1);
    cur_req = "R5";  tall_r = 1;
    tick(1, 0, 0, 0); run_lines(530, 0);
    cur_req = "R6";  std_r = 1; tall_r = 0;
    tick(1, 0, 0, 0); run_lines(630, 1);
    cur_req = "R7";  tall_r = 1;
    tick(1, 0, 0, 0); run_lines(300, 0);

    // R9: register write and mode change mid-frame stay dormant
    cur_req = "R9";
    tick(0, 0, 1, 30);
    std_r = 0; tall_r = 0;
    run_lines(340, 0);

    cur_req = "R8";
    tick(1, 0, 0, 0); run_lines(530, 0);
    tick(0, 0, 1, 0);
    tick(1, 0, 0, 0); run_lines(300, 0);
    tick(0, 0, 1, 700);
    tick(1, 0, 0, 0); run_lines(300, 0);
    tick(0, 0, 1, 500); std_r = 1;
    tick(1, 0, 0, 0); run_lines(630, 0);

    // R9: write coinciding with frame start waits one frame
    cur_req = "R9";
    tick(1, 0, 1, 40); run_lines(100, 0);
    tick(1, 0, 0, 0);  run_lines(100, 0);

    // R2: frame restart mid-frame, frame and line pulse together
    cur_req = "R2";
    tick(1, 1, 0, 0); run_lines(10, 1);
    tick(1, 0, 0, 0); run_lines(5, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog: got no finish exp finish within 200000 cycles");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule